// File: doc/BRIEF.md
# Shared Packet Page Allocator

This block hands out a small pool of packet pages that the transmit and receive paths share. A bitmask records which pages are in use. Three page-number queues hang off it: pages waiting to go out, pages already sent and waiting for the host to notice, and pages holding received frames. The host drives the allocator through a one-byte command and reads an allocation result, the heads of the completion and receive queues, and an interrupt status byte. The interrupt status byte has a mask and a write-one-to-clear acknowledge.

The receive side asks for a page. If one is granted, the page is taken from the pool and appended to the receive queue in the same cycle. The transmit side takes pages from the head of the transmit queue. Each sent page is either returned to the pool at once or parked in the completion queue, depending on the auto-release input. A transmit allocation that finds the pool full does not fail for good. It stays pending and completes on the next release of any page.

Only one event is applied per cycle, in a fixed priority: host command, then acknowledge, then receive grant, then transmit take. A mask write is independent of these and can happen in any cycle.

Top module: `pkt_page_mmu`

## Requirements
- R1: After reset the interrupt status reads 0x04 (only transmit-empty set), the mask reads 0x00, irq is low, the allocation result reads 0x00, the completion head and receive head both read 0x80, and tx_valid is low.
- R2: The command code sits in cmd_byte bits 7:5. Code 1 (allocate) first sets the result to 0x80 and clears status bit 3. If a page is free, the lowest-numbered one is marked used, its number becomes the result, and status bit 3 is set. If no page is free, the result stays 0x80 and bit 3 stays clear.
- R3: A release (codes 4 or 5, or an auto-release) made while the result reads 0x80 completes the pending allocation in the same cycle: the result becomes the lowest free page and status bit 3 is set. A release with no pending allocation leaves the result unchanged.
- R4: A receive request is granted when a page is free and the receive queue has room. rx_page gives the lowest free page. That page is marked used and pushed onto the receive queue, and status bit 0 is set.
- R5: Code 3 pops the receive queue. Code 4 frees the receive head page and then pops. After either, status bit 0 stays set if entries remain and is cleared if the queue is empty.
- R6: Code 5 frees the page named by pkt_sel. Code 6 appends pkt_sel to the transmit queue. The transmit port presents the queue head on tx_page while tx_valid is high, and removes it on an accepted tx_pop.
- R7: A page taken by the transmit port is freed at once when auto_release is high. Otherwise it is appended to the completion queue.
- R8: An acknowledge clears the status bits selected by ack_data AND 0xD6, so bits 3 and 0 cannot be cleared this way. Acknowledging bit 1 also pops the completion queue.
- R9: Status bit 2 (transmit empty) is set in every cycle in which the transmit queue is empty. Status bit 1 (transmit done) is set in every cycle in which the completion queue is not empty. Status bits 7:4 always read 0.
- R10: irq is high exactly when status AND mask is non-zero. A mask write takes effect on the next clock edge.
- R11: Code 2 empties the pool and all three queues and sets the result to 0x00. Code 7 empties the transmit and completion queues only.
- R12: A push onto a full queue is dropped, and a pop from an empty queue changes nothing. A receive request is refused while the receive queue is full.
- R13: In a cycle with cmd_wr or ack_wr high, no receive grant and no transmit take happen. A receive grant blocks a transmit take in the same cycle. If cmd_wr and ack_wr are both high, the acknowledge is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Host command strobe |
| cmd_byte | input | 8 | Command byte, code in bits 7:5 |
| pkt_sel | input | 2 | Page number used by release and transmit enqueue |
| ack_wr | input | 1 | Interrupt acknowledge strobe |
| ack_data | input | 8 | Status bits to clear |
| mask_wr | input | 1 | Interrupt mask write strobe |
| mask_data | input | 8 | New interrupt mask |
| auto_release | input | 1 | Free transmitted pages instead of queueing them |
| rx_req | input | 1 | Receive side asks for a page |
| rx_grant | output | 1 | Receive request accepted this cycle |
| rx_page | output | 2 | Page given to the receive side |
| tx_pop | input | 1 | Transmit side takes the queue head |
| tx_valid | output | 1 | Transmit queue not empty |
| tx_page | output | 2 | Transmit queue head |
| tx_accept | output | 1 | Transmit take accepted this cycle |
| alloc_result | output | 8 | Allocation result, 0x80 while pending |
| done_head | output | 8 | Completion queue head, 0x80 when empty |
| rx_head | output | 8 | Receive queue head, 0x80 when empty |
| irq_status | output | 8 | Interrupt status bits |
| irq_mask | output | 8 | Interrupt mask |
| irq | output | 1 | Interrupt request |

## Verification
A stale or wrong bit in the used-page mask shows up at the next allocation or receive grant as the wrong page number, or as an unexpected 0x80. The sweeps therefore release every subset of a full pool and check the very next result. A queue count that is off by one shows within one cycle: the head outputs, tx_valid and the transmit-empty and transmit-done status bits are all compared right after each push and pop. A missed pending retry shows in the cycle after the release, as a result still reading 0x80 with the allocation bit clear.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_ALLOC   = 3'd1,
    OP_RESET   = 3'd2,
    OP_RXPOP   = 3'd3,
    OP_RXFREE  = 3'd4,
    OP_RELEASE = 3'd5,
    OP_TXQ     = 3'd6,
    OP_TXCLR   = 3'd7
  } op_e;

  typedef enum logic [2:0] {
    EV_IDLE,
    EV_CMD,
    EV_ACK,
    EV_RX,
    EV_TX
  } ev_e;

  localparam int ST_RCV     = 0;
  localparam int ST_TXDONE  = 1;
  localparam int ST_TXEMPTY = 2;
  localparam int ST_ALLOC   = 3;

  localparam logic [7:0] ACK_CLEARABLE = 8'hD6;
  localparam logic [7:0] NO_PAGE       = 8'h80;
  localparam logic [7:0] STATUS_RESET  = 8'h04;

endpackage

// File: rtl/ppm_lowfree.sv
module ppm_lowfree #(
  parameter int NUM_PAGES = 4,
  localparam int PW = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1
) (
  input  logic [NUM_PAGES-1:0] used,
  output logic                 found,
  output logic [PW-1:0]        idx
);

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = NUM_PAGES - 1; i >= 0; i--) begin
      if (!used[i]) begin
        found = 1'b1;
        idx   = PW'(i);
      end
    end
  end

endmodule

// File: rtl/ppm_queue.sv
module ppm_queue #(
  parameter int DEPTH = 4,
  parameter int DW    = 2,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count,
  output logic          empty,
  output logic          full
);

  logic [DW-1:0] slot_q [DEPTH];
  logic [DW-1:0] slot_d [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic          slot_en;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));
  assign head  = slot_q[0];
  assign count = cnt_q;

  always_comb begin
    cnt_d   = cnt_q;
    slot_en = 1'b0;
    for (int i = 0; i < DEPTH; i++) slot_d[i] = slot_q[i];
    if (clr) begin
      cnt_d = '0;
    end else if (pop && !empty) begin
      slot_en = 1'b1;
      for (int i = 0; i < DEPTH - 1; i++) slot_d[i] = slot_q[i+1];
      cnt_d = cnt_q - 1'b1;
    end else if (push && !full) begin
      slot_en = 1'b1;
      slot_d[cnt_q[IW-1:0]] = din;
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    if (slot_en) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
    end
  end

endmodule

// File: rtl/pkt_page_mmu.sv
module pkt_page_mmu
  import ppm_pkg::*;
#(
  parameter int NUM_PAGES = 4,
  localparam int PW = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1,
  localparam int CW = $clog2(NUM_PAGES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_wr,
  input  logic [7:0]    cmd_byte,
  input  logic [PW-1:0] pkt_sel,
  input  logic          ack_wr,
  input  logic [7:0]    ack_data,
  input  logic          mask_wr,
  input  logic [7:0]    mask_data,
  input  logic          auto_release,
  input  logic          rx_req,
  output logic          rx_grant,
  output logic [PW-1:0] rx_page,
  input  logic          tx_pop,
  output logic          tx_valid,
  output logic [PW-1:0] tx_page,
  output logic          tx_accept,
  output logic [7:0]    alloc_result,
  output logic [7:0]    done_head,
  output logic [7:0]    rx_head,
  output logic [7:0]    irq_status,
  output logic [7:0]    irq_mask,
  output logic          irq
);

  logic [NUM_PAGES-1:0] used_q, used_d, used_rel;
  logic [7:0]           result_q, result_d;
  logic [7:0]           stat_q, stat_d;
  logic [7:0]           mask_q;

  logic          fnow_ok, frel_ok;
  logic [PW-1:0] fnow_idx, frel_idx;

  logic          txq_clr, txq_push, txq_pop;
  logic          dnq_clr, dnq_push, dnq_pop;
  logic          rxq_clr, rxq_push, rxq_pop;
  logic [PW-1:0] txq_din, dnq_din;
  logic [PW-1:0] txq_head, dnq_head, rxq_head;
  logic [CW-1:0] txq_cnt, dnq_cnt, rxq_cnt;
  logic          txq_empty, dnq_empty, rxq_empty;
  logic          txq_full, dnq_full, rxq_full;

  ev_e           ev;
  op_e           op;
  logic          rel_en;
  logic [PW-1:0] rel_page;
  logic          tx_empty_nx, done_busy_nx;

  assign op = op_e'(cmd_byte[7:5]);

  ppm_lowfree #(.NUM_PAGES(NUM_PAGES)) u_free_now (
    .used (used_q),
    .found(fnow_ok),
    .idx  (fnow_idx)
  );

  ppm_lowfree #(.NUM_PAGES(NUM_PAGES)) u_free_rel (
    .used (used_rel),
    .found(frel_ok),
    .idx  (frel_idx)
  );

  ppm_queue #(.DEPTH(NUM_PAGES), .DW(PW)) u_txq (
    .clk(clk), .rst_n(rst_n), .clr(txq_clr), .push(txq_push), .pop(txq_pop),
    .din(txq_din), .head(txq_head), .count(txq_cnt), .empty(txq_empty), .full(txq_full)
  );

  ppm_queue #(.DEPTH(NUM_PAGES), .DW(PW)) u_dnq (
    .clk(clk), .rst_n(rst_n), .clr(dnq_clr), .push(dnq_push), .pop(dnq_pop),
    .din(dnq_din), .head(dnq_head), .count(dnq_cnt), .empty(dnq_empty), .full(dnq_full)
  );

  ppm_queue #(.DEPTH(NUM_PAGES), .DW(PW)) u_rxq (
    .clk(clk), .rst_n(rst_n), .clr(rxq_clr), .push(rxq_push), .pop(rxq_pop),
    .din(fnow_idx), .head(rxq_head), .count(rxq_cnt), .empty(rxq_empty), .full(rxq_full)
  );

  // one event per cycle: host command > acknowledge > receive > transmit
  always_comb begin
    if (cmd_wr)                          ev = EV_CMD;
    else if (ack_wr)                     ev = EV_ACK;
    else if (rx_req && fnow_ok && !rxq_full) ev = EV_RX;
    else if (tx_pop && !txq_empty)       ev = EV_TX;
    else                                 ev = EV_IDLE;
  end

  // page freed this cycle, if any
  always_comb begin
    rel_en   = 1'b0;
    rel_page = pkt_sel;
    if (ev == EV_CMD && op == OP_RXFREE && !rxq_empty) begin
      rel_en   = 1'b1;
      rel_page = rxq_head;
    end else if (ev == EV_CMD && op == OP_RELEASE) begin
      rel_en   = 1'b1;
      rel_page = pkt_sel;
    end else if (ev == EV_TX && auto_release) begin
      rel_en   = 1'b1;
      rel_page = txq_head;
    end
    used_rel = used_q & ~(NUM_PAGES'(1) << rel_page);
  end

  always_comb begin
    used_d   = used_q;
    result_d = result_q;
    stat_d   = stat_q;
    txq_clr  = 1'b0; txq_push = 1'b0; txq_pop = 1'b0; txq_din = pkt_sel;
    dnq_clr  = 1'b0; dnq_push = 1'b0; dnq_pop = 1'b0; dnq_din = txq_head;
    rxq_clr  = 1'b0; rxq_push = 1'b0; rxq_pop = 1'b0;

    unique case (ev)
      EV_CMD: begin
        unique case (op)
          OP_ALLOC: begin
            result_d         = NO_PAGE;
            stat_d[ST_ALLOC] = 1'b0;
            if (fnow_ok) begin
              used_d           = used_q | (NUM_PAGES'(1) << fnow_idx);
              result_d         = {{(8-PW){1'b0}}, fnow_idx};
              stat_d[ST_ALLOC] = 1'b1;
            end
          end
          OP_RESET: begin
            used_d   = '0;
            result_d = 8'h00;
            txq_clr  = 1'b1;
            dnq_clr  = 1'b1;
            rxq_clr  = 1'b1;
          end
          OP_RXPOP, OP_RXFREE: begin
            rxq_pop        = 1'b1;
            stat_d[ST_RCV] = (rxq_cnt > CW'(1));
          end
          OP_TXQ:   txq_push = 1'b1;
          OP_TXCLR: begin
            txq_clr = 1'b1;
            dnq_clr = 1'b1;
          end
          default: ;
        endcase
      end
      EV_ACK: begin
        stat_d  = stat_q & ~(ack_data & ACK_CLEARABLE);
        dnq_pop = ack_data[ST_TXDONE];
      end
      EV_RX: begin
        used_d         = used_q | (NUM_PAGES'(1) << fnow_idx);
        rxq_push       = 1'b1;
        stat_d[ST_RCV] = 1'b1;
      end
      EV_TX: begin
        txq_pop  = 1'b1;
        dnq_push = !auto_release;
      end
      default: ;
    endcase

    if (rel_en) begin
      used_d = used_rel;
      if (result_q[7] && frel_ok) begin
        used_d           = used_rel | (NUM_PAGES'(1) << frel_idx);
        result_d         = {{(8-PW){1'b0}}, frel_idx};
        stat_d[ST_ALLOC] = 1'b1;
      end
    end

    tx_empty_nx  = txq_clr || (txq_empty && !txq_push) ||
                   (txq_cnt == CW'(1) && txq_pop);
    done_busy_nx = !dnq_clr && (dnq_push ||
                   (!dnq_empty && !(dnq_cnt == CW'(1) && dnq_pop)));
    if (tx_empty_nx)  stat_d[ST_TXEMPTY] = 1'b1;
    if (done_busy_nx) stat_d[ST_TXDONE]  = 1'b1;
    stat_d[7:4] = 4'h0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q   <= '0;
      result_q <= 8'h00;
      stat_q   <= STATUS_RESET;
      mask_q   <= 8'h00;
    end else begin
      used_q   <= used_d;
      result_q <= result_d;
      stat_q   <= stat_d;
      if (mask_wr) mask_q <= mask_data;
    end
  end

  assign rx_grant     = (ev == EV_RX);
  assign rx_page      = fnow_idx;
  assign tx_accept    = (ev == EV_TX);
  assign tx_valid     = !txq_empty;
  assign tx_page      = txq_head;
  assign alloc_result = result_q;
  assign done_head    = dnq_empty ? NO_PAGE : {{(8-PW){1'b0}}, dnq_head};
  assign rx_head      = rxq_empty ? NO_PAGE : {{(8-PW){1'b0}}, rxq_head};
  assign irq_status   = stat_q;
  assign irq_mask     = mask_q;
  assign irq          = |(stat_q & mask_q);

endmodule

// File: rtl/ppm_checker.sv
module ppm_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr,
  input logic [7:0] cmd_byte,
  input logic       rx_grant,
  input logic       tx_valid,
  input logic       tx_accept,
  input logic [7:0] alloc_result,
  input logic [7:0] done_head,
  input logic [7:0] rx_head,
  input logic [7:0] irq_status
);

  p_tx_empty_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_valid |-> irq_status[2]);

  p_done_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done_head[7] |-> irq_status[1]);

  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_status[7:4] == 4'h0);

  p_alloc_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_byte[7:5] == 3'd1) |=> (alloc_result[7] != irq_status[3]));

  p_rx_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_grant |=> (!rx_head[7] && irq_status[0]));

  p_txclr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_byte[7:5] == 3'd7) |=> (!tx_valid && done_head == 8'h80));

  p_host_first_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |-> (!rx_grant && !tx_accept));

endmodule

bind pkt_page_mmu ppm_checker u_ppm_checker (
  .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte),
  .rx_grant(rx_grant), .tx_valid(tx_valid), .tx_accept(tx_accept),
  .alloc_result(alloc_result), .done_head(done_head), .rx_head(rx_head),
  .irq_status(irq_status)
);

// File: tb/test_pkt_page_mmu.sv
module test_pkt_page_mmu;

  localparam int NP = 4;
  localparam logic [2:0] C_ALLOC = 3'd1, C_RESET = 3'd2, C_RXPOP = 3'd3,
                         C_RXFREE = 3'd4, C_REL = 3'd5, C_TXQ = 3'd6, C_TXCLR = 3'd7;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cmd_wr, ack_wr, mask_wr, auto_release, rx_req, tx_pop;
  logic [7:0] cmd_byte, ack_data, mask_data;
  logic [1:0] pkt_sel;
  logic       rx_grant, tx_valid, tx_accept, irq;
  logic [1:0] rx_page, tx_page;
  logic [7:0] alloc_result, done_head, rx_head, irq_status, irq_mask;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pkt_page_mmu #(.NUM_PAGES(NP)) i_pkt_page_mmu (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_byte(cmd_byte), .pkt_sel(pkt_sel),
    .ack_wr(ack_wr), .ack_data(ack_data), .mask_wr(mask_wr), .mask_data(mask_data),
    .auto_release(auto_release), .rx_req(rx_req), .rx_grant(rx_grant), .rx_page(rx_page),
    .tx_pop(tx_pop), .tx_valid(tx_valid), .tx_page(tx_page), .tx_accept(tx_accept),
    .alloc_result(alloc_result), .done_head(done_head), .rx_head(rx_head),
    .irq_status(irq_status), .irq_mask(irq_mask), .irq(irq)
  );

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic host(input logic [2:0] code, input int sel);
    cmd_byte = {code, 5'b0};
    pkt_sel  = sel[1:0];
    cmd_wr   = 1'b1;
    @(negedge clk);
    cmd_wr   = 1'b0;
  endtask

  task automatic ack(input logic [7:0] d);
    ack_data = d; ack_wr = 1'b1;
    @(negedge clk);
    ack_wr = 1'b0;
  endtask

  task automatic set_mask(input logic [7:0] d);
    mask_data = d; mask_wr = 1'b1;
    @(negedge clk);
    mask_wr = 1'b0;
  endtask

  task automatic rx_try(output bit g, output int pg);
    rx_req = 1'b1;
    #1;
    g = rx_grant; pg = rx_page;
    @(negedge clk);
    rx_req = 1'b0;
  endtask

  task automatic tx_try(output bit a, output int pg);
    tx_pop = 1'b1;
    #1;
    a = tx_accept; pg = tx_page;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic fill_pool();
    host(C_RESET, 0);
    for (int i = 0; i < NP; i++) host(C_ALLOC, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    bit g;
    int pg;
    rst_n = 1'b0;
    cmd_wr = 0; ack_wr = 0; mask_wr = 0; auto_release = 0; rx_req = 0; tx_pop = 0;
    cmd_byte = 0; ack_data = 0; mask_data = 0; pkt_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 status", irq_status, 8'h04);
    check("R1 mask", irq_mask, 8'h00);
    check("R1 irq", irq, 0);
    check("R1 result", alloc_result, 8'h00);
    check("R1 done head", done_head, 8'h80);
    check("R1 rx head", rx_head, 8'h80);
    check("R1 tx_valid", tx_valid, 0);

    // R10 masking
    set_mask(8'h04); check("R10 irq with tx-empty unmasked", irq, 1);
    set_mask(8'h00); check("R10 irq masked off", irq, 0);
    set_mask(8'h08); check("R10 irq alloc bit clear", irq, 0);

    // R2 sweep: free every subset of a full pool, expect the lowest freed page
    for (int s = 1; s < (1 << NP); s++) begin
      int low;
      fill_pool();
      low = -1;
      for (int b = NP - 1; b >= 0; b--) if (s[b]) begin host(C_REL, b); low = b; end
      host(C_ALLOC, 0);
      check("R2 lowest free", alloc_result, low);
      check("R2 alloc bit", irq_status[3], 1);
    end

    // R3 pending allocation retried on each possible release
    for (int k = 0; k < NP; k++) begin
      fill_pool();
      host(C_ALLOC, 0);
      check("R2 full result", alloc_result, 8'h80);
      check("R2 full alloc bit", irq_status[3], 0);
      check("R10 irq low while pending", irq, 0);
      host(C_REL, k);
      check("R3 retry result", alloc_result, k);
      check("R3 retry alloc bit", irq_status[3], 1);
      check("R10 irq after retry", irq, 1);
    end

    // R3 no retry when nothing pending
    host(C_RESET, 0);
    host(C_ALLOC, 0); host(C_ALLOC, 0);
    host(C_REL, 0);
    check("R3 no pending keeps result", alloc_result, 1);
    host(C_ALLOC, 0);
    check("R3 freed page reused", alloc_result, 0);

    // R11 reset command
    host(C_RESET, 0);
    check("R11 reset result", alloc_result, 0);

    // R4 R5 R12 receive path
    for (int i = 0; i < NP; i++) begin
      rx_try(g, pg);
      check("R4 grant", g, 1);
      check("R4 page", pg, i);
    end
    check("R4 rx head", rx_head, 0);
    check("R4 rcv bit", irq_status[0], 1);
    rx_try(g, pg);
    check("R12 rx full refused", g, 0);
    ack(8'h01);
    check("R8 rcv not ackable", irq_status[0], 1);
    host(C_RXPOP, 0);
    check("R5 pop head", rx_head, 1);
    check("R5 rcv kept", irq_status[0], 1);
    host(C_RXFREE, 0);
    check("R5 free+pop head", rx_head, 2);
    rx_try(g, pg);
    check("R5 freed page regranted", pg, 1);
    check("R4 regrant", g, 1);
    host(C_RXFREE, 0); check("R5 head 3", rx_head, 3);
    host(C_RXFREE, 0); check("R5 head 1", rx_head, 1);
    host(C_RXFREE, 0);
    check("R5 empty head", rx_head, 8'h80);
    check("R5 rcv cleared", irq_status[0], 0);
    host(C_RXPOP, 0);
    check("R12 empty pop head", rx_head, 8'h80);
    check("R12 empty pop rcv", irq_status[0], 0);
    host(C_ALLOC, 0);
    check("R5 popped-only page stays used", alloc_result, 1);

    // R6 R7 R8 R9 transmit path
    host(C_RESET, 0);
    host(C_ALLOC, 0);
    host(C_TXQ, 0);
    check("R6 tx_valid", tx_valid, 1);
    check("R6 tx_page", tx_page, 0);
    check("R9 tx-empty sticky", irq_status[2], 1);
    ack(8'h04);
    check("R8 tx-empty acked", irq_status[2], 0);
    host(C_TXQ, 3);
    auto_release = 0;
    tx_try(g, pg);
    check("R6 take accepted", g, 1);
    check("R6 take page", pg, 0);
    check("R7 done head", done_head, 0);
    check("R9 done bit", irq_status[1], 1);
    tx_try(g, pg);
    check("R6 second page", pg, 3);
    check("R6 queue drained", tx_valid, 0);
    check("R9 tx-empty reset", irq_status[2], 1);
    ack(8'h02);
    check("R8 ack pops done", done_head, 3);
    check("R9 done still set", irq_status[1], 1);
    ack(8'h02);
    check("R8 done empty", done_head, 8'h80);
    check("R8 done bit cleared", irq_status[1], 0);
    ack(8'hFF);
    check("R8 mask 0xD6 status", irq_status, 8'h0C);
    tx_try(g, pg);
    check("R12 empty take refused", g, 0);

    // R7 auto release completes a pending allocation
    fill_pool();
    host(C_ALLOC, 0);
    host(C_TXQ, 1);
    auto_release = 1;
    tx_try(g, pg);
    auto_release = 0;
    check("R7 auto take", g, 1);
    check("R7 auto freed retry", alloc_result, 1);
    check("R7 no done entry", done_head, 8'h80);

    // R12 transmit queue overflow and order
    host(C_RESET, 0);
    for (int i = 0; i < NP; i++) host(C_TXQ, i);
    host(C_TXQ, 2);
    for (int i = 0; i < NP; i++) begin
      tx_try(g, pg);
      check("R12 order", pg, i);
    end
    check("R12 extra push dropped", tx_valid, 0);
    check("R7 done head first", done_head, 0);
    host(C_TXCLR, 0);
    check("R11 done cleared", done_head, 8'h80);
    check("R11 tx cleared", tx_valid, 0);

    // R13 arbitration
    host(C_RESET, 0);
    host(C_TXQ, 2);
    cmd_byte = 8'h00; cmd_wr = 1'b1; rx_req = 1'b1;
    #1;
    check("R13 host blocks rx", rx_grant, 0);
    @(negedge clk);
    cmd_wr = 1'b0;
    tx_pop = 1'b1;
    #1;
    check("R13 rx blocks tx", tx_accept, 0);
    check("R13 rx granted", rx_grant, 1);
    @(negedge clk);
    rx_req = 1'b0;
    #1;
    check("R13 tx after rx", tx_accept, 1);
    @(negedge clk);
    tx_pop = 1'b0;
    ack_data = 8'h02; ack_wr = 1'b1; cmd_byte = 8'h00; cmd_wr = 1'b1;
    @(negedge clk);
    ack_wr = 1'b0; cmd_wr = 1'b0;
    check("R13 ack dropped under cmd", done_head, 2);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule